// File: doc/BRIEF.md
# Power-Management Bus Command Channel

A register-mapped channel through which a processor starts one transaction at a time on a serial power-management bus and later polls for its outcome. Software first loads up to eight payload bytes into two 32-bit write-data registers, then writes a command word. That write launches the transaction: the opcode, slave id, register address, byte count and payload go out on a simple request/acknowledge port toward the bus engine. The channel then waits for a response.

The response is one of four codes: success, no acknowledge, denied or dropped. It lands in a sticky four-bit status register, where a done flag qualifies the three error flags. On a successful read, the returned bytes are captured into two read-data registers, and bytes beyond the requested count are cleared. If no response arrives within a parameterised number of cycles, the channel reports a failure by itself. An opcode the channel does not support fails at once, without any request being sent.

Top module: `cmd_chan`

## Requirements
- R1: After reset the status register, both write-data registers, both read-data registers and `txn_req_o` are all zero.
- R2: A command word is laid out with the opcode in bits 31:27, the slave id in bits 23:20, the address in bits 19:4 and the byte count minus one in bits 2:0. Its fields appear on the `txn_*` outputs, and `txn_req_o` goes high, in the cycle after the command register (offset 0x00) is written. They stay there until a response arrives.
- R3: Payload bytes 0–3 are written at offset 0x10 and bytes 4–7 at offset 0x14, least significant byte first, and are presented as `txn_wdata_o = {reg 0x14, reg 0x10}`. The payload is captured when the command is accepted, so later writes to the data registers do not change a transaction in flight.
- R4: The status register sits at offset 0x08, with bit 0 done, bit 1 failure, bit 2 denied and bit 3 dropped. The response codes on `txn_resp_i` map as follows: 0 success gives 0x1, 1 no-acknowledge gives 0x3, 2 denied gives 0x5 and 3 dropped gives 0x9. No error bit is ever set without done.
- R5: Status clears to zero when a command is accepted and reads zero for as long as the transaction is in flight.
- R6: A command-register write made while a transaction is in flight is ignored. The outstanding request fields, the payload and the status are all unchanged.
- R7: The read-data registers sit at offset 0x18 (bytes 0–3) and offset 0x1C (bytes 4–7). They update only when a read opcode (1, 13 or 15) completes with success, and bytes above the byte count are stored as zero. Failed reads and all writes leave them unchanged.
- R8: The control opcodes 3 to 6 are sent with the slave id only; the address, byte count and payload go out as zero.
- R9: If `txn_ack_i` has not been seen within `TIMEOUT_CYCLES` clock edges after acceptance, the request drops and status becomes 0x3. The request is still pending at edge `TIMEOUT_CYCLES-1`.
- R10: The supported opcodes are 0–6 and 13–16. Any other opcode sets status to 0x3 in the cycle after the command write and never raises `txn_req_o`.
- R11: `txn_ack_i` has no effect while no transaction is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational from address) |
| txn_req_o | output | 1 | Transaction request, held until response |
| txn_opc_o | output | 5 | Opcode |
| txn_sid_o | output | 4 | Slave id |
| txn_addr_o | output | 16 | Register address on the bus |
| txn_bc_o | output | 3 | Byte count minus one |
| txn_wdata_o | output | 64 | Payload, byte 0 in bits 7:0 |
| txn_ack_i | input | 1 | Response valid |
| txn_resp_i | input | 2 | Response code: 0 success, 1 no-ack, 2 denied, 3 dropped |
| txn_rdata_i | input | 64 | Returned read bytes |

## Verification
The bench targets the following corner cases:

- **Response codes.** Each code is exercised. A design that mixed up the error bits, or set one without done, would return the wrong status value.
- **Partial reads.** Short reads are checked for zeroing of the bytes above the count. Failed reads and writes are checked to leave the previous read data in place; a design that captured data unconditionally would lose that data.
- **Busy period.** A second command and a payload change are issued while a transaction is in flight. A design that did not latch at acceptance would alter the request in mid-flight.
- **Timeout.** The cycle on which the timeout fires is checked on both sides, so an off-by-one counter is caught.
- **Illegal and control opcodes.** These are checked to fail at once and to send no payload, respectively.
- **Stray acknowledge.** An acknowledge while idle must leave the status untouched.

// File: rtl/cmd_chan_pkg.sv
package cmd_chan_pkg;
  localparam int unsigned REG_AW   = 5;
  localparam int unsigned REG_DW   = 32;
  localparam int unsigned OPC_W    = 5;
  localparam int unsigned SID_W    = 4;
  localparam int unsigned BADDR_W  = 16;
  localparam int unsigned BC_W     = 3;
  localparam int unsigned NBYTES   = 1 << BC_W;
  localparam int unsigned PAY_W    = NBYTES * 8;
  localparam int unsigned ST_W     = 4;

  localparam logic [REG_AW-1:0] OFF_CMD = 5'h00;
  localparam logic [REG_AW-1:0] OFF_ST  = 5'h08;
  localparam logic [REG_AW-1:0] OFF_WD0 = 5'h10;
  localparam logic [REG_AW-1:0] OFF_WD1 = 5'h14;
  localparam logic [REG_AW-1:0] OFF_RD0 = 5'h18;
  localparam logic [REG_AW-1:0] OFF_RD1 = 5'h1C;

  // status bit positions
  localparam int unsigned ST_DONE = 0;
  localparam int unsigned ST_FAIL = 1;
  localparam int unsigned ST_DENY = 2;
  localparam int unsigned ST_DROP = 3;

  typedef enum logic [1:0] {RSP_OK = 2'd0, RSP_NACK = 2'd1, RSP_DENY = 2'd2, RSP_DROP = 2'd3} rsp_e;
  typedef enum logic [1:0] {K_BAD = 2'd0, K_WRITE = 2'd1, K_READ = 2'd2, K_CTRL = 2'd3} kind_e;

  typedef struct packed {
    logic [OPC_W-1:0]   opc;
    logic [2:0]         rsvd_hi;
    logic [SID_W-1:0]   sid;
    logic [BADDR_W-1:0] addr;
    logic               rsvd_lo;
    logic [BC_W-1:0]    bc;
  } cmd_t;
endpackage

// File: rtl/cmd_chan_decode.sv
module cmd_chan_decode
  import cmd_chan_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  output kind_e            kind_o
);
  always_comb begin
    unique case (opc_i)
      5'd0, 5'd2, 5'd14, 5'd16: kind_o = K_WRITE;
      5'd1, 5'd13, 5'd15:       kind_o = K_READ;
      5'd3, 5'd4, 5'd5, 5'd6:   kind_o = K_CTRL;
      default:                  kind_o = K_BAD;
    endcase
  end
endmodule

// File: rtl/cmd_chan_regs.sv
module cmd_chan_regs
  import cmd_chan_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o,
  input  logic [REG_DW-1:0] cmd_last_i,
  input  logic [ST_W-1:0]   status_i,
  input  logic [PAY_W-1:0]  rd_i,
  output logic [PAY_W-1:0]  wd_o,
  output logic              cmd_wr_o
);
  localparam int unsigned NWORDS = PAY_W / REG_DW;

  logic [REG_DW-1:0] wd_q [NWORDS];

  for (genvar w = 0; w < NWORDS; w++) begin : g_wd
    localparam logic [REG_AW-1:0] OFF = OFF_WD0 + REG_AW'(4 * w);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          wd_q[w] <= '0;
      else if (reg_we_i && reg_addr_i == OFF) wd_q[w] <= reg_wdata_i;
    end
    assign wd_o[w*REG_DW +: REG_DW] = wd_q[w];
  end

  assign cmd_wr_o = reg_we_i && (reg_addr_i == OFF_CMD);

  always_comb begin
    unique case (reg_addr_i)
      OFF_CMD: reg_rdata_o = cmd_last_i;
      OFF_ST:  reg_rdata_o = REG_DW'(status_i);
      OFF_WD0: reg_rdata_o = wd_q[0];
      OFF_WD1: reg_rdata_o = wd_q[1];
      OFF_RD0: reg_rdata_o = rd_i[0 +: REG_DW];
      OFF_RD1: reg_rdata_o = rd_i[REG_DW +: REG_DW];
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cmd_chan_seq.sv
module cmd_chan_seq
  import cmd_chan_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_wr_i,
  input  logic [REG_DW-1:0]  cmd_word_i,
  input  kind_e              kind_i,
  input  logic [PAY_W-1:0]   wd_i,
  output logic [REG_DW-1:0]  cmd_last_o,
  output logic [ST_W-1:0]    status_o,
  output logic [PAY_W-1:0]   rd_o,
  output logic               txn_req_o,
  output logic [OPC_W-1:0]   txn_opc_o,
  output logic [SID_W-1:0]   txn_sid_o,
  output logic [BADDR_W-1:0] txn_addr_o,
  output logic [BC_W-1:0]    txn_bc_o,
  output logic [PAY_W-1:0]   txn_wdata_o,
  input  logic               txn_ack_i,
  input  logic [1:0]         txn_resp_i,
  input  logic [PAY_W-1:0]   txn_rdata_i
);
  localparam int unsigned CNT_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  cmd_t             cmd;
  logic             busy_q, is_rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PAY_W-1:0] keep_mask;
  rsp_e             rsp;

  assign cmd = cmd_t'(cmd_word_i);
  assign rsp = rsp_e'(txn_resp_i);
  assign txn_req_o = busy_q;

  for (genvar b = 0; b < NBYTES; b++) begin : g_mask
    assign keep_mask[b*8 +: 8] = (BC_W'(b) <= txn_bc_o) ? 8'hFF : 8'h00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      is_rd_q     <= 1'b0;
      cnt_q       <= '0;
      status_o    <= '0;
      rd_o        <= '0;
      cmd_last_o  <= '0;
      txn_opc_o   <= '0;
      txn_sid_o   <= '0;
      txn_addr_o  <= '0;
      txn_bc_o    <= '0;
      txn_wdata_o <= '0;
    end else if (!busy_q) begin
      if (cmd_wr_i) begin
        cmd_last_o <= cmd_word_i;
        if (kind_i == K_BAD) begin
          status_o <= ST_W'((1 << ST_DONE) | (1 << ST_FAIL));
        end else begin
          status_o    <= '0;
          busy_q      <= 1'b1;
          is_rd_q     <= (kind_i == K_READ);
          cnt_q       <= '0;
          txn_opc_o   <= cmd.opc;
          txn_sid_o   <= cmd.sid;
          txn_addr_o  <= (kind_i == K_CTRL) ? '0 : cmd.addr;
          txn_bc_o    <= (kind_i == K_CTRL) ? '0 : cmd.bc;
          txn_wdata_o <= (kind_i == K_CTRL) ? '0 : wd_i;
        end
      end
    end else if (txn_ack_i) begin
      busy_q <= 1'b0;
      unique case (rsp)
        RSP_OK:   status_o <= ST_W'(1 << ST_DONE);
        RSP_NACK: status_o <= ST_W'((1 << ST_DONE) | (1 << ST_FAIL));
        RSP_DENY: status_o <= ST_W'((1 << ST_DONE) | (1 << ST_DENY));
        RSP_DROP: status_o <= ST_W'((1 << ST_DONE) | (1 << ST_DROP));
        default:  status_o <= ST_W'((1 << ST_DONE) | (1 << ST_FAIL));
      endcase
      if (rsp == RSP_OK && is_rd_q) rd_o <= txn_rdata_i & keep_mask;
    end else if (cnt_q == CNT_LAST) begin
      busy_q   <= 1'b0;
      status_o <= ST_W'((1 << ST_DONE) | (1 << ST_FAIL));
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_REQ_FIELDS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_req_o && !txn_ack_i |=> $stable({txn_opc_o, txn_sid_o, txn_addr_o, txn_bc_o, txn_wdata_o})); // R6
  AST_STATUS_ZERO_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_req_o |-> status_o == '0); // R5
  AST_ERR_NEEDS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|status_o[ST_DROP:ST_FAIL]) |-> status_o[ST_DONE]); // R4
  AST_SINGLE_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(status_o[ST_DROP:ST_FAIL]) <= 1); // R4
  AST_CTRL_NO_PAYLOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_req_o && txn_opc_o >= 5'd3 && txn_opc_o <= 5'd6 |-> txn_addr_o == '0 && txn_bc_o == '0); // R8
  AST_TIMEOUT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> cnt_q <= CNT_LAST); // R9
  AST_IDLE_ACK_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !txn_req_o && !cmd_wr_i && txn_ack_i |=> $stable(status_o)); // R11
  AST_RD_ONLY_ON_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(txn_req_o && txn_ack_i && rsp == RSP_OK) |=> $stable(rd_o)); // R7
endmodule

// File: rtl/cmd_chan.sv
module cmd_chan
  import cmd_chan_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [REG_AW-1:0]  reg_addr_i,
  input  logic [REG_DW-1:0]  reg_wdata_i,
  output logic [REG_DW-1:0]  reg_rdata_o,
  output logic               txn_req_o,
  output logic [OPC_W-1:0]   txn_opc_o,
  output logic [SID_W-1:0]   txn_sid_o,
  output logic [BADDR_W-1:0] txn_addr_o,
  output logic [BC_W-1:0]    txn_bc_o,
  output logic [PAY_W-1:0]   txn_wdata_o,
  input  logic               txn_ack_i,
  input  logic [1:0]         txn_resp_i,
  input  logic [PAY_W-1:0]   txn_rdata_i
);
  logic              cmd_wr;
  logic [PAY_W-1:0]  wd, rd;
  logic [REG_DW-1:0] cmd_last;
  logic [ST_W-1:0]   status;
  kind_e             kind;

  cmd_chan_regs u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .cmd_last_i(cmd_last), .status_i(status), .rd_i(rd), .wd_o(wd), .cmd_wr_o(cmd_wr)
  );

  cmd_chan_decode u_dec (
    .opc_i(reg_wdata_i[REG_DW-1 -: OPC_W]), .kind_o(kind)
  );

  cmd_chan_seq #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_seq (
    .clk_i, .rst_ni, .cmd_wr_i(cmd_wr), .cmd_word_i(reg_wdata_i), .kind_i(kind),
    .wd_i(wd), .cmd_last_o(cmd_last), .status_o(status), .rd_o(rd),
    .txn_req_o, .txn_opc_o, .txn_sid_o, .txn_addr_o, .txn_bc_o, .txn_wdata_o,
    .txn_ack_i, .txn_resp_i, .txn_rdata_i
  );
endmodule

// File: tb/sim_cmd_chan.sv
module sim_cmd_chan;
  localparam int CLK_PERIOD = 10;
  localparam int TO = 64;

  typedef struct packed {
    logic [31:0] cmd;
    logic [63:0] wd;
    logic [1:0]  rsp;
    logic [63:0] rin;
    logic [3:0]  st;
  } vec_t;

  function automatic logic [31:0] mk(input logic [4:0] opc, input logic [3:0] sid,
                                     input logic [15:0] addr, input logic [2:0] bc);
    return {opc, 3'b000, sid, addr, 1'b0, bc};
  endfunction

  localparam vec_t VECS [7] = '{
    '{cmd: {5'd14, 3'b0, 4'd3, 16'h1234, 1'b0, 3'd3}, wd: 64'h0000_0000_4433_2211, rsp: 2'd0, rin: 64'h0, st: 4'h1},
    '{cmd: {5'd15, 3'b0, 4'd5, 16'h00A0, 1'b0, 3'd7}, wd: 64'h0, rsp: 2'd0, rin: 64'h8877_6655_4433_2211, st: 4'h1},
    '{cmd: {5'd13, 3'b0, 4'd1, 16'hBEEF, 1'b0, 3'd1}, wd: 64'h0, rsp: 2'd0, rin: 64'hFFFF_FFFF_FFFF_ABCD, st: 4'h1},
    '{cmd: {5'd1,  3'b0, 4'd2, 16'h0042, 1'b0, 3'd5}, wd: 64'h0, rsp: 2'd1, rin: 64'h1111_2222_3333_4444, st: 4'h3},
    '{cmd: {5'd2,  3'b0, 4'hF, 16'h7701, 1'b0, 3'd7}, wd: 64'hDEAD_BEEF_CAFE_F00D, rsp: 2'd2, rin: 64'h0, st: 4'h5},
    '{cmd: {5'd16, 3'b0, 4'd9, 16'h0010, 1'b0, 3'd0}, wd: 64'h0000_0000_0000_0055, rsp: 2'd3, rin: 64'h0, st: 4'h9},
    '{cmd: {5'd1,  3'b0, 4'd6, 16'h8001, 1'b0, 3'd4}, wd: 64'h0, rsp: 2'd0, rin: 64'hA1A2_A3A4_A5A6_A7A8, st: 4'h1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic req, ack = 1'b0;
  logic [4:0] opc;
  logic [3:0] sid;
  logic [15:0] baddr;
  logic [2:0] bc;
  logic [63:0] twd, trd = '0;
  logic [1:0] resp = '0;
  int n_chk = 0, n_bad = 0;
  logic [63:0] exp_rd = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_chan #(.TIMEOUT_CYCLES(TO)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .txn_req_o(req), .txn_opc_o(opc), .txn_sid_o(sid),
    .txn_addr_o(baddr), .txn_bc_o(bc), .txn_wdata_o(twd), .txn_ack_i(ack),
    .txn_resp_i(resp), .txn_rdata_i(trd)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic respond(input logic [1:0] r, input logic [63:0] din);
    while (!req) @(negedge clk);
    ack = 1'b1; resp = r; trd = din;
    @(negedge clk); ack = 1'b0;
  endtask

  function automatic logic [63:0] keep(input logic [63:0] d, input logic [2:0] n);
    logic [63:0] m = '0;
    for (int b = 0; b < 8; b++) if (b <= int'(n)) m[b*8 +: 8] = 8'hFF;
    return d & m;
  endfunction

  initial begin : wdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 req", 64'(req), 64'd0);
    rd(5'h08, v); chk("R1 status", 64'(v), 64'd0);
    rd(5'h10, v); chk("R1 wd0", 64'(v), 64'd0);
    rd(5'h14, v); chk("R1 wd1", 64'(v), 64'd0);
    rd(5'h18, v); chk("R1 rd0", 64'(v), 64'd0);
    rd(5'h1C, v); chk("R1 rd1", 64'(v), 64'd0);

    // table walk: R2 R3 R4 R7
    for (int i = 0; i < 7; i++) begin
      vec_t t = VECS[i];
      wr(5'h10, t.wd[31:0]);
      wr(5'h14, t.wd[63:32]);
      wr(5'h00, t.cmd);
      chk("R2 req", 64'(req), 64'd1);
      chk("R2 opc", 64'(opc), 64'(t.cmd[31:27]));
      chk("R2 sid", 64'(sid), 64'(t.cmd[23:20]));
      chk("R2 addr", 64'(baddr), 64'(t.cmd[19:4]));
      chk("R2 bc", 64'(bc), 64'(t.cmd[2:0]));
      chk("R3 payload", twd, t.wd);
      rd(5'h08, v); chk("R5 busy status", 64'(v), 64'd0);
      respond(t.rsp, t.rin);
      rd(5'h08, v); chk("R4 status", 64'(v), 64'(t.st));
      chk("R2 req drop", 64'(req), 64'd0);
      if ((t.cmd[31:27] == 5'd1 || t.cmd[31:27] == 5'd13 || t.cmd[31:27] == 5'd15) && t.rsp == 2'd0)
        exp_rd = keep(t.rin, t.cmd[2:0]);
      rd(5'h18, v); chk("R7 rd0", 64'(v), 64'(exp_rd[31:0]));
      rd(5'h1C, v); chk("R7 rd1", 64'(v), 64'(exp_rd[63:32]));
    end

    // R6 / R3: command and payload changes while busy
    wr(5'h10, 32'h0102_0304);
    wr(5'h14, 32'h0506_0708);
    wr(5'h00, mk(5'd14, 4'd4, 16'h0ABC, 3'd7));
    wr(5'h10, 32'hFFFF_FFFF);
    wr(5'h00, mk(5'd15, 4'd8, 16'h5555, 3'd2));
    chk("R6 opc held", 64'(opc), 64'd14);
    chk("R6 addr held", 64'(baddr), 64'h0ABC);
    chk("R3 payload held", twd, 64'h0506_0708_0102_0304);
    rd(5'h08, v); chk("R5 status during busy", 64'(v), 64'd0);
    respond(2'd0, 64'h0);
    rd(5'h00, v); chk("R6 cmd reg keeps first", 64'(v), 64'(mk(5'd14, 4'd4, 16'h0ABC, 3'd7)));

    // R8 control opcode
    wr(5'h00, mk(5'd4, 4'd7, 16'hFFFF, 3'd7));
    chk("R8 sid", 64'(sid), 64'd7);
    chk("R8 addr", 64'(baddr), 64'd0);
    chk("R8 bc", 64'(bc), 64'd0);
    chk("R8 payload", twd, 64'd0);
    respond(2'd0, 64'h0);
    rd(5'h08, v); chk("R8 status", 64'(v), 64'd1);

    // R9 timeout boundary
    wr(5'h00, mk(5'd15, 4'd1, 16'h0001, 3'd0));
    repeat (TO - 1) @(negedge clk);
    chk("R9 still pending", 64'(req), 64'd1);
    @(negedge clk);
    chk("R9 req dropped", 64'(req), 64'd0);
    rd(5'h08, v); chk("R9 timeout status", 64'(v), 64'd3);
    rd(5'h18, v); chk("R7 rd after timeout", 64'(v), 64'(exp_rd[31:0]));

    // R10 unsupported opcode
    wr(5'h00, mk(5'd9, 4'd2, 16'h0100, 3'd1));
    chk("R10 no req", 64'(req), 64'd0);
    rd(5'h08, v); chk("R10 status", 64'(v), 64'd3);

    // R11 stray ack while idle
    wr(5'h00, mk(5'd14, 4'd2, 16'h0100, 3'd0));
    respond(2'd0, 64'h0);
    @(negedge clk); ack = 1'b1; resp = 2'd2;
    @(negedge clk); ack = 1'b0;
    @(negedge clk);
    rd(5'h08, v); chk("R11 idle ack", 64'(v), 64'd1);
    chk("R11 no req", 64'(req), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule